// File: doc/BRIEF.md
# Dual-Synthesizer Power Sequencing Controller

This block decides when each of two synthesizer channels, an RF channel and an IF channel, may leave power-down. Both channels are set up through one bank of seven programming registers that are loaded serially. Words are shifted in MSB first and latched by a load strobe. The low bits of each latched word carry the register address. The block keeps one "written" flag per register. A channel's enable rises only after every register in that channel's set has been loaded. Register 3 belongs to both sets.

While a channel is powered down, the block holds that channel's control outputs in their safe state. Those outputs are: counter load-state force, charge-pump three-state, lock-detect reset and input debias. The serial input register keeps shifting and latching at all times. Configuration written while a channel is down is therefore kept. The IF phase-detector polarity and IF charge-pump current are latched from register 4 and brought out for the analog side.

Top module: `synpwr_seq`

## Requirements
- R1: After reset, rf_en and if_en are 0, every written flag is clear, all eight force outputs are 1, and if_pd_pol and if_cp_cur are 0.
- R2: The serial register shifts sdata in MSB first on each cycle with sshift high. On a cycle with sload high, the last 24 bits shifted in form the word. Word bits [2:0] are the register address.
- R3: rf_en is 1 exactly when registers 0, 1, 2 and 3 have all been loaded since their flags were last cleared. This holds for any write order, and rf_en is visible on the cycle after the completing load.
- R4: if_en is 1 exactly when registers 3, 4, 5 and 6 have all been loaded, in any write order. Register 3 counts toward both channels.
- R5: Loading only registers 0 to 3 leaves if_en at 0. Loading only registers 3 to 6 leaves rf_en at 0.
- R6: While rf_en is 0, rf_cnt_load, rf_cp_tristate, rf_ld_reset and rf_in_debias are all 1. While rf_en is 1, all four are 0.
- R7: While if_en is 0, if_cnt_load, if_cp_tristate, if_ld_reset and if_in_debias are all 1. While if_en is 1, all four are 0.
- R8: A load of register 4 updates if_pd_pol from word bit 7 (1 for a positive VCO slope) and if_cp_cur from word bits [10:8]. This happens even while the IF channel is powered down.
- R9: A load of register 3 with word bit 4 set clears the flags of registers 0 to 2. With word bit 5 set, it clears the flags of registers 4 to 6. The register 3 flag itself is still set, and the other channel is not affected.
- R10: A load with address 7 sets no flag and changes no output.
- R11: Shifting without a load strobe changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial data bit |
| sshift | input | 1 | Shift enable for the serial register |
| sload | input | 1 | Load strobe that latches the shifted word |
| rf_en | output | 1 | RF channel powered up |
| if_en | output | 1 | IF channel powered up |
| rf_cnt_load | output | 1 | Hold RF counters in load state |
| rf_cp_tristate | output | 1 | Force RF charge pump to three-state |
| rf_ld_reset | output | 1 | Hold RF lock detect in reset |
| rf_in_debias | output | 1 | Debias RF input |
| if_cnt_load | output | 1 | Hold IF counters in load state |
| if_cp_tristate | output | 1 | Force IF charge pump to three-state |
| if_ld_reset | output | 1 | Hold IF lock detect in reset |
| if_in_debias | output | 1 | Debias IF input |
| if_pd_pol | output | 1 | IF phase-detector polarity |
| if_cp_cur | output | 3 | IF charge-pump current code |

## Verification
The bench builds the block with its default parameters. These are a 24-bit word, a 3-bit address, seven registers, register 3 as the shared one, and the power-down and configuration bits named above. With seven registers the address space has exactly one unused code, 7, so the out-of-range path can be reached. Each four-register set has only 24 orders, so every write order of each channel's set is run from reset, with both enables checked after every load. Partial sets, explicit power-down through register 3, and extra leading bits on the serial line cover the shared-register and framing cases.

// File: rtl/synpwr_pkg.sv
package synpwr_pkg;

    typedef struct packed {
        logic cnt_load;
        logic cp_tristate;
        logic ld_reset;
        logic in_debias;
    } chan_ctl_t;

    localparam int CH_RF = 0;
    localparam int CH_IF = 1;
    localparam int NUM_CH = 2;

endpackage

// File: rtl/synpwr_shifter.sv
module synpwr_shifter #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              sshift,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (sshift) sr_d = {sr_q[WORD_W-2:0], sdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word = sr_q;
endmodule

// File: rtl/synpwr_tracker.sv
module synpwr_tracker #(
    parameter int WORD_W     = 24,
    parameter int ADDR_W     = 3,
    parameter int NUM_REGS   = 7,
    parameter int SHARED_IDX = 3,
    parameter int RF_PD_BIT  = 4,
    parameter int IF_PD_BIT  = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WORD_W-1:0]   word,
    output logic [NUM_REGS-1:0] written
);
    logic [NUM_REGS-1:0] wr_d, wr_q;
    logic [ADDR_W-1:0]   addr;

    assign addr = word[ADDR_W-1:0];

    always_comb begin
        wr_d = wr_q;
        if (load && (int'(addr) < NUM_REGS)) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (addr == ADDR_W'(i)) wr_d[i] = 1'b1;
            end
            if (addr == ADDR_W'(SHARED_IDX)) begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (word[RF_PD_BIT] && (i < SHARED_IDX)) wr_d[i] = 1'b0;
                    if (word[IF_PD_BIT] && (i > SHARED_IDX)) wr_d[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign written = wr_q;
endmodule

// File: rtl/synpwr_chan.sv
module synpwr_chan
    import synpwr_pkg::*;
(
    input  logic      en,
    output chan_ctl_t ctl
);
    always_comb begin
        ctl.cnt_load    = !en;
        ctl.cp_tristate = !en;
        ctl.ld_reset    = !en;
        ctl.in_debias   = !en;
    end
endmodule

// File: rtl/synpwr_seq.sv
module synpwr_seq
    import synpwr_pkg::*;
#(
    parameter int WORD_W     = 24,
    parameter int ADDR_W     = 3,
    parameter int NUM_REGS   = 7,
    parameter int SHARED_IDX = 3,
    parameter int RF_PD_BIT  = 4,
    parameter int IF_PD_BIT  = 5,
    parameter int IF_CFG_IDX = 4,
    parameter int POL_BIT    = 7,
    parameter int CUR_LSB    = 8,
    parameter int CUR_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdata,
    input  logic             sshift,
    input  logic             sload,
    output logic             rf_en,
    output logic             if_en,
    output logic             rf_cnt_load,
    output logic             rf_cp_tristate,
    output logic             rf_ld_reset,
    output logic             rf_in_debias,
    output logic             if_cnt_load,
    output logic             if_cp_tristate,
    output logic             if_ld_reset,
    output logic             if_in_debias,
    output logic             if_pd_pol,
    output logic [CUR_W-1:0] if_cp_cur
);
    localparam int LAST_IDX = NUM_REGS - 1;

    typedef struct packed {
        logic             pol;
        logic [CUR_W-1:0] cur;
    } cfg_t;

    logic [WORD_W-1:0]   word;
    logic [NUM_REGS-1:0] written;
    logic [NUM_CH-1:0]   ch_en;
    chan_ctl_t           ch_ctl [NUM_CH];
    cfg_t                cfg_d, cfg_q;

    synpwr_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .sshift(sshift), .word(word)
    );

    synpwr_tracker #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
        .SHARED_IDX(SHARED_IDX), .RF_PD_BIT(RF_PD_BIT), .IF_PD_BIT(IF_PD_BIT)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .load(sload), .word(word), .written(written)
    );

    assign ch_en[CH_RF] = &written[SHARED_IDX:0];
    assign ch_en[CH_IF] = &written[LAST_IDX:SHARED_IDX];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        synpwr_chan u_chan (.en(ch_en[c]), .ctl(ch_ctl[c]));
    end

    always_comb begin
        cfg_d = cfg_q;
        if (sload && (word[ADDR_W-1:0] == ADDR_W'(IF_CFG_IDX))) begin
            cfg_d.pol = word[POL_BIT];
            cfg_d.cur = word[CUR_LSB +: CUR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rf_en          = ch_en[CH_RF];
    assign if_en          = ch_en[CH_IF];
    assign rf_cnt_load    = ch_ctl[CH_RF].cnt_load;
    assign rf_cp_tristate = ch_ctl[CH_RF].cp_tristate;
    assign rf_ld_reset    = ch_ctl[CH_RF].ld_reset;
    assign rf_in_debias   = ch_ctl[CH_RF].in_debias;
    assign if_cnt_load    = ch_ctl[CH_IF].cnt_load;
    assign if_cp_tristate = ch_ctl[CH_IF].cp_tristate;
    assign if_ld_reset    = ch_ctl[CH_IF].ld_reset;
    assign if_in_debias   = ch_ctl[CH_IF].in_debias;
    assign if_pd_pol      = cfg_q.pol;
    assign if_cp_cur      = cfg_q.cur;
endmodule

// File: rtl/synpwr_seq_chk.sv
module synpwr_seq_chk #(
    parameter int NUM_REGS = 7,
    parameter int CUR_W    = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sload,
    input logic [NUM_REGS-1:0] written,
    input logic                rf_en,
    input logic                if_en,
    input logic                rf_cnt_load,
    input logic                rf_cp_tristate,
    input logic                rf_ld_reset,
    input logic                rf_in_debias,
    input logic                if_cnt_load,
    input logic                if_cp_tristate,
    input logic                if_ld_reset,
    input logic                if_in_debias,
    input logic                if_pd_pol,
    input logic [CUR_W-1:0]    if_cp_cur
);
    AST_RF_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_en |-> (rf_cnt_load && rf_cp_tristate && rf_ld_reset && rf_in_debias)); // R6
    AST_RF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |-> !(rf_cnt_load || rf_cp_tristate || rf_ld_reset || rf_in_debias)); // R6
    AST_IF_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en |-> (if_cnt_load && if_cp_tristate && if_ld_reset && if_in_debias)); // R7
    AST_IF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        if_en |-> !(if_cnt_load || if_cp_tristate || if_ld_reset || if_in_debias)); // R7
    AST_RF_UP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_en) |-> $past(sload)); // R3
    AST_IF_UP_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_en) |-> $past(sload)); // R4
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sload) |-> $stable(written)); // R11
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sload) |-> ($stable(if_cp_cur) && $stable(if_pd_pol))); // R11
endmodule

bind synpwr_seq synpwr_seq_chk #(.NUM_REGS(NUM_REGS), .CUR_W(CUR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sload(sload), .written(written),
    .rf_en(rf_en), .if_en(if_en),
    .rf_cnt_load(rf_cnt_load), .rf_cp_tristate(rf_cp_tristate),
    .rf_ld_reset(rf_ld_reset), .rf_in_debias(rf_in_debias),
    .if_cnt_load(if_cnt_load), .if_cp_tristate(if_cp_tristate),
    .if_ld_reset(if_ld_reset), .if_in_debias(if_in_debias),
    .if_pd_pol(if_pd_pol), .if_cp_cur(if_cp_cur)
);

// File: tb/tb_synpwr_seq.sv
module tb_synpwr_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdata = 1'b0, sshift = 1'b0, sload = 1'b0;
    logic rf_en, if_en;
    logic rf_cnt_load, rf_cp_tristate, rf_ld_reset, rf_in_debias;
    logic if_cnt_load, if_cp_tristate, if_ld_reset, if_in_debias;
    logic if_pd_pol;
    logic [2:0] if_cp_cur;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    synpwr_seq dut (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .sshift(sshift), .sload(sload),
        .rf_en(rf_en), .if_en(if_en),
        .rf_cnt_load(rf_cnt_load), .rf_cp_tristate(rf_cp_tristate),
        .rf_ld_reset(rf_ld_reset), .rf_in_debias(rf_in_debias),
        .if_cnt_load(if_cnt_load), .if_cp_tristate(if_cp_tristate),
        .if_ld_reset(if_ld_reset), .if_in_debias(if_in_debias),
        .if_pd_pol(if_pd_pol), .if_cp_cur(if_cp_cur)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sshift = 1'b0; sload = 1'b0; sdata = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic shift_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = v[i]; sshift = 1'b1;
            @(negedge clk);
        end
        sshift = 1'b0;
    endtask

    task automatic write_reg(logic [23:0] w);
        shift_bits({8'h00, w}, 24);
        sload = 1'b1;
        @(negedge clk);
        sload = 1'b0;
    endtask

    function automatic logic [3:0] forces_rf();
        return {rf_cnt_load, rf_cp_tristate, rf_ld_reset, rf_in_debias};
    endfunction
    function automatic logic [3:0] forces_if();
        return {if_cnt_load, if_cp_tristate, if_ld_reset, if_in_debias};
    endfunction

    task automatic t_reset_state();
        do_reset();
        chk("R1 rf_en", rf_en, 0);
        chk("R1 if_en", if_en, 0);
        chk("R1 rf forces", forces_rf(), 15);
        chk("R1 if forces", forces_if(), 15);
        chk("R1 pol", if_pd_pol, 0);
        chk("R1 cur", if_cp_cur, 0);
    endtask

    task automatic t_all_orders(bit is_if);
        int base = is_if ? 3 : 0;
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int d = 0; d < 4; d++) begin
                        int ord[4];
                        if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
                        ord = '{a, b, c, d};
                        do_reset();
                        for (int k = 0; k < 4; k++) begin
                            write_reg(24'(base + ord[k]));
                            if (is_if) begin
                                chk("R4 if_en order", if_en, (k == 3) ? 1 : 0);
                                chk("R5 rf_en stays off", rf_en, 0);
                            end else begin
                                chk("R3 rf_en order", rf_en, (k == 3) ? 1 : 0);
                                chk("R5 if_en stays off", if_en, 0);
                            end
                        end
                        if (is_if) begin
                            chk("R7 if released", forces_if(), 0);
                            chk("R6 rf forced", forces_rf(), 15);
                        end else begin
                            chk("R6 rf released", forces_rf(), 0);
                            chk("R7 if forced", forces_if(), 15);
                        end
                    end
    endtask

    task automatic t_both_and_powerdown();
        do_reset();
        for (int r = 0; r < 7; r++) write_reg(24'(r));
        chk("R3 rf_en both", rf_en, 1);
        chk("R4 if_en both", if_en, 1);
        write_reg(24'h000013);          // reg 3, RF power-down bit 4
        chk("R9 rf down", rf_en, 0);
        chk("R9 if kept", if_en, 1);
        chk("R6 rf forced again", forces_rf(), 15);
        write_reg(24'd0); write_reg(24'd1);
        chk("R9 rf partial", rf_en, 0);
        write_reg(24'd2);
        chk("R9 rf back, reg3 flag kept", rf_en, 1);
        write_reg(24'h000023);          // reg 3, IF power-down bit 5
        chk("R9 if down", if_en, 0);
        chk("R9 rf kept", rf_en, 1);
        write_reg(24'd4); write_reg(24'd5);
        chk("R9 if partial", if_en, 0);
        write_reg(24'd6);
        chk("R9 if back", if_en, 1);
        chk("R7 if released", forces_if(), 0);
    endtask

    task automatic t_config_and_ignored();
        do_reset();
        write_reg(24'h000584);          // reg 4, pol=1, cur=5
        chk("R8 pol while down", if_pd_pol, 1);
        chk("R8 cur while down", if_cp_cur, 5);
        chk("R8 if still down", if_en, 0);
        write_reg(24'd0); write_reg(24'd1); write_reg(24'd2);
        write_reg(24'h00023F);          // address 7 with stray bits
        chk("R10 rf not completed", rf_en, 0);
        chk("R10 pol kept", if_pd_pol, 1);
        chk("R10 cur kept", if_cp_cur, 5);
        write_reg(24'h000304);          // reg 4, pol=0, cur=3
        chk("R8 pol update", if_pd_pol, 0);
        chk("R8 cur update", if_cp_cur, 3);
    endtask

    task automatic t_framing();
        do_reset();
        shift_bits(32'h3F, 6);          // junk shifted out before the word
        write_reg(24'h000684);          // reg 4, pol=1, cur=6
        chk("R2 framed pol", if_pd_pol, 1);
        chk("R2 framed cur", if_cp_cur, 6);
        shift_bits(32'h00000303, 24);   // reg 3 pattern, no strobe
        repeat (2) @(negedge clk);
        chk("R11 cur unchanged", if_cp_cur, 6);
        write_reg(24'd5); write_reg(24'd6);
        chk("R11 if not up without reg3", if_en, 0);
        write_reg(24'd3);
        chk("R2 reg3 load completes IF", if_en, 1);
    endtask

    initial begin
        t_reset_state();
        t_all_orders(1'b0);
        t_all_orders(1'b1);
        t_both_and_powerdown();
        t_config_and_ignored();
        t_framing();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule